// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of a classic 8-bit microcontroller external memory bus. The address-latch strobe (`ale`, active high) tells external logic when to capture the low address byte. The program-fetch strobe (`psen_n`, active low) reads external code memory. Time is counted in machine cycles. Each machine cycle holds `NUM_STATES` states, and each state holds two phases. A divide-by-two stage creates the phases, with one phase per input clock period. Because every register acts on the same clock edge, the duty cycle of the input clock has no effect on the strobes.

At the first edge of each machine cycle the block samples two inputs. The first says whether code is fetched from external memory. The second says whether this cycle performs an external data memory access. While code runs from internal memory, the fetch strobe stays inactive. During a data access cycle, the second address-latch pulse and both fetch pulses are dropped. This leaves the bus free for the data transfer. The `cycle_start` output marks the first clock period of every machine cycle, so that a controller can line up its requests.

Top module: `bus_strobe_seq`

## Requirements
- R1: While `rst` is high, and in the first clock period after it is released, `ale` is 0, `psen_n` is 1 and `cycle_start` is 1. The sampled mode and data-access flags are cleared.
- R2: A machine cycle lasts 2*`NUM_STATES` clock periods, 12 with the default. Position p counts 0 to 11 from the first period, and `cycle_start` is 1 exactly at position 0.
- R3: `ale` is high for one clock period at position 1 (second phase of the first state) and at position 7 (second phase of the fourth state). This gives a rate of one sixth of the input clock when no data access takes place.
- R4: When external code is selected for the cycle (`ext_code`=1 sampled), `psen_n` is 0 at positions 2, 3, 8 and 9 and 1 elsewhere. These are two activations per machine cycle.
- R5: When internal code is selected for the cycle (`ext_code`=0 sampled), `psen_n` stays 1 for the whole cycle.
- R6: In a data access cycle (`xdata_req`=1 sampled), the `ale` pulse at position 7 is omitted and the pulse at position 1 is kept.
- R7: In a data access cycle, both `psen_n` activations are omitted, whatever the code source.
- R8: `ext_code` and `xdata_req` are sampled only at the clock edge that enters position 0. Changes at other times have no effect until the next cycle. The first cycle after reset behaves as internal code with no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst | input | 1 | Synchronous reset, active high |
| ext_code | input | 1 | 1 = code fetched from external program memory |
| xdata_req | input | 1 | 1 = next machine cycle is an external data access |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| cycle_start | output | 1 | High in the first clock period of each machine cycle |

## Verification
The bench builds the block with `NUM_STATES` = 6, which is the standard twelve-period machine cycle. With this value every position of the cycle, both strobe slots and the wrap-around edge are observed within a few hundred clocks. The vector table covers all four combinations of code source and data access, including back-to-back data cycles and a switch of the code source. Mid-cycle glitches on the request inputs show that only the cycle-start edge matters. A reset in the middle of a cycle shows that the first cycle after reset is fetch-free.

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq #(
  parameter int NUM_STATES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_code,
  input  logic xdata_req,
  output logic ale,
  output logic psen_n,
  output logic cycle_start
);
  localparam int SW  = (NUM_STATES > 2) ? $clog2(NUM_STATES) : 1;
  localparam int MID = NUM_STATES / 2;

  logic          ph;
  logic [SW-1:0] st;
  logic          code_q, data_q;
  logic          last;

  assign last = ph && (st == SW'(NUM_STATES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      st     <= '0;
      code_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) st <= last ? '0 : st + SW'(1);
      if (last) begin
        code_q <= ext_code;
        data_q <= xdata_req;
      end
    end
  end

  assign ale         = ph && ((st == '0) || ((st == SW'(MID)) && !data_q));
  assign psen_n      = !(code_q && !data_q && ((st == SW'(1)) || (st == SW'(MID + 1))));
  assign cycle_start = !ph && (st == '0);
endmodule

module bus_strobe_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic cycle_start
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!ale && psen_n && cycle_start));
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst) cycle_start |=> !cycle_start);
  // R6
  first_ale_kept_chk: assert property (@(posedge clk) disable iff (rst) cycle_start |=> ale);
  // R4
  psen_width_chk: assert property (@(posedge clk) disable iff (rst) $fell(psen_n) |=> !psen_n);
  // R7
  strobe_apart_chk: assert property (@(posedge clk) disable iff (rst) !psen_n |-> (!ale && !cycle_start));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .cycle_start(cycle_start)
);

// File: tb/sim_bus_strobe_seq.sv
`timescale 1ns/1ps
module sim_bus_strobe_seq;
  logic clk = 1'b0, rst = 1'b1, ext_code = 1'b0, xdata_req = 1'b0;
  logic ale, psen_n, cycle_start;
  int tests = 0, fails = 0;
  logic done = 1'b0;

  bus_strobe_seq #(.NUM_STATES(6)) u0 (
    .clk(clk), .rst(rst), .ext_code(ext_code), .xdata_req(xdata_req),
    .ale(ale), .psen_n(psen_n), .cycle_start(cycle_start)
  );

  always #4 clk = ~clk;

  // {ext_code, xdata_req} per machine cycle
  localparam logic [1:0] VEC [10] = '{2'b10, 2'b10, 2'b11, 2'b10, 2'b00,
                                      2'b01, 2'b11, 2'b11, 2'b00, 2'b10};

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic chk_pos(input int p, input logic code, input logic data);
    logic e_ale, e_psen;
    e_ale  = (p == 1) || (p == 7 && !data);
    e_psen = !(code && !data && (p == 2 || p == 3 || p == 8 || p == 9));
    chk(data ? "R6 ale" : "R3 ale", ale, e_ale);
    chk(data ? "R7 psen_n" : (code ? "R4 psen_n" : "R5 psen_n"), psen_n, e_psen);
    chk("R2 cycle_start", cycle_start, p == 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic cc, cd;
    int n_ale, n_psen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ale", ale, 1'b0);
    chk("R1 psen_n", psen_n, 1'b1);
    chk("R1 cycle_start", cycle_start, 1'b1);
    rst = 1'b0;
    chk_pos(0, 1'b0, 1'b0);
    cc = 1'b0; cd = 1'b0;
    for (int c = 0; c <= 10; c++) begin
      for (int k = 1; k <= 12; k++) begin
        if (k == 5 && c < 10) begin
          ext_code = ~VEC[c][1]; xdata_req = ~VEC[c][0];  // R8 glitch mid-cycle
        end
        if (k == 12 && c < 10) begin
          ext_code = VEC[c][1]; xdata_req = VEC[c][0];
        end
        @(posedge clk); @(negedge clk);
        if (k == 12 && c < 10) begin cc = VEC[c][1]; cd = VEC[c][0]; end
        if (c < 10 || k < 12) chk_pos(k % 12, cc, cd);
      end
    end

    // R1 / R8: reset mid-cycle, first cycle after reset is fetch-free
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1; ext_code = 1'b1; xdata_req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 ale", ale, 1'b0);
    chk("R1 psen_n", psen_n, 1'b1);
    chk("R1 cycle_start", cycle_start, 1'b1);
    rst = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); @(negedge clk);
      if (k < 12) chk_pos(k, 1'b0, 1'b0);   // R8 first cycle internal
      else chk_pos(0, 1'b1, 1'b0);
    end

    // R3 / R4: rate over ten cycles of external fetch
    n_ale = 0; n_psen = 0;
    for (int k = 0; k < 120; k++) begin
      @(posedge clk); @(negedge clk);
      if (ale) n_ale++;
      if (!psen_n) n_psen++;
    end
    chk("R3 ale count", n_ale == 20, 1'b1);
    chk("R4 psen_n low count", n_psen == 40, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule